// File: doc/BRIEF.md
# Byte-Sequenced SPI Host Controller

This block is an SPI master that software drives one byte at a time through a small 8-bit register bus. Software loads a data register and selects either a write cycle or a read cycle. It then issues a start command that names channel 0 or channel 1. The engine shifts exactly eight bits and raises a byte-done flag. Between bytes it leaves the chosen chip select asserted, so a multi-byte transaction is built from a chain of start commands. The transaction closes only when software issues an end-of-transmission command. That command releases the chip select and raises a transfer-end flag.

Both flags feed a single interrupt line behind an enable bit, and software clears each flag by writing 1 to it. The serial clock polarity and phase are programmable. The bit rate comes from a 3-bit divider index. The table behind that index depends on the clock source: the fast source ticks every cycle of `clk`, and the slow source ticks once per pulse on `slow_tick`.

Register offsets: 0x0 data, 0x1 mode (bit 6 polarity, bit 5 phase, bits 4:2 divider index, bit 1 interrupt enable), 0x2 cycle (bit 2 read cycle, bit 1 blocking select, stored only), 0x3 status/command, 0x4 byte flag (bit 4), 0x5 source (bit 6 fast source).

Top module: `spi_byte_host`

## Requirements
- R1: After reset, every register at offsets 0x0 to 0x5 reads 0x00, both chip selects read high, `sck` is low and `irq` is low.
- R2: A write cycle (offset 0x2 bit 2 = 0) shifts the data register out on `mosi`, MSB first.
- R3: A read cycle (offset 0x2 bit 2 = 1) drives `mosi` high for all eight bits. It captures eight `miso` bits MSB first, and the data register then reads back that byte.
- R4: `sck` idles at the polarity bit (offset 0x1 bit 6). With phase 0 (bit 5) data is sampled on the leading edge of each bit and changed on the trailing edge. With phase 1 data changes on the leading edge and is sampled on the trailing edge.
- R5: With the fast source selected (offset 0x5 bit 6 = 1), divider indices 0..7 set the `sck` half-period to 2, 4, 6, 8, 10, 12, 14 and 1 clocks. The byte-done flag then reads set 16*N+1 clocks after the start write.
- R6: With the slow source selected (offset 0x5 bit 6 = 0), indices 0..7 set the half-period to 2, 4, 6, 8, 10, 12, 14 and 16 `slow_tick` pulses.
- R7: Each completed byte sets the byte-done flag (offset 0x4 bit 4). Writing 1 to that bit clears it.
- R8: A start command uses offset 0x3 bit 4 for channel 0 and bit 3 for channel 1, with bit 4 winning when both are set. It drives only that channel's active-low chip select low, and the select stays low across later bytes. While a select is held, a start naming the other channel is ignored.
- R9: Writing offset 0x3 bit 5 (end command) while no byte is shifting releases the chip select and sets transfer end (bit 1). Bit 1 is cleared by writing 1 to it, and a single write that carries both the end command and the clear leaves the flag set.
- R10: `irq` is high exactly when the interrupt enable (offset 0x1 bit 1) is set and either byte-done or transfer end is set.
- R11: A start command or an end command written while a byte is shifting has no effect: the byte keeps its timing and the chip select does not change.
- R12: Status bit 2 reads 1 while a byte is shifting. Status bit 6 reads 1 while a chip select is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast serial clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request, intended for rising-edge detection |
| slow_tick | input | 1 | One-cycle pulse per period of the slow source clock |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects, bit 0 for channel 0 |

## Verification
The set and the clear of the transfer-end flag can land in the same clock edge. This happens when one status write carries both the end command and the write-1-clear of bit 1. The bench issues that combined write and then reads status: the flag must still be set, so setting takes priority. A start command and an in-flight byte also meet in one cycle. The bench fires start and end commands partway through a byte and judges them by the byte's total duration, an unchanged chip select, and a scoreboard that must see exactly one byte on the wire.

// File: rtl/spi_byte_host_pkg.sv
package spi_byte_host_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned NUM_CS = 2;
  localparam int unsigned HP_W   = 5;   // holds the largest half-period, 16
  localparam int unsigned IDX_W  = 3;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 3'h1;
  localparam logic [ADDR_W-1:0] OFS_CYCLE = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'h3;
  localparam logic [ADDR_W-1:0] OFS_BFLAG = 3'h4;
  localparam logic [ADDR_W-1:0] OFS_SRC   = 3'h5;

  // mode register fields
  localparam int unsigned B_CPOL   = 6;
  localparam int unsigned B_CPHA   = 5;
  localparam int unsigned B_DIV_LO = 2;
  localparam int unsigned B_IEN    = 1;
  // cycle register fields
  localparam int unsigned B_RDCYC  = 2;
  localparam int unsigned B_BLOCK  = 1;
  // status / command fields
  localparam int unsigned B_DEVBSY = 6;
  localparam int unsigned B_END    = 5;
  localparam int unsigned B_GO0    = 4;
  localparam int unsigned B_GO1    = 3;
  localparam int unsigned B_XIP    = 2;
  localparam int unsigned B_TEND   = 1;
  localparam int unsigned B_BUSBSY = 0;
  // byte flag / source fields
  localparam int unsigned B_BDONE  = 4;
  localparam int unsigned B_FAST   = 6;

  // Half-period of sck in source ticks for a divider index.
  // Both tables run 2,4,..,14; the last slot is 1 on the fast source and 16 on the slow one.
  function automatic logic [HP_W-1:0] half_period(input logic [IDX_W-1:0] idx,
                                                  input logic fast);
    logic [HP_W-1:0] hp;
    if (fast && idx == 3'd7) hp = HP_W'(1);
    else                     hp = HP_W'({idx, 1'b0}) + HP_W'(2);
    return hp;
  endfunction

endpackage

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast_src,
  input  logic             slow_tick,
  input  logic [CNT_W-1:0] half_len,
  output logic             edge_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             at_end;

  assign tick   = fast_src | slow_tick;
  assign at_end = (cnt_q == half_len - CNT_W'(1));
  assign edge_o = run & tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (edge_o)  cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         edge_i,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         active,
  output logic         done_p,
  output logic [W-1:0] rx
);
  localparam int unsigned EW = $clog2(2 * W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

  logic          lvl_q, act_q, done_q, mosi_q;
  logic [EW-1:0] ecnt_q;
  logic [W-1:0]  tx_sr, rx_sr, rx_q;

  logic         leading, sample_now, shift_now, last_edge, step;
  logic [W-1:0] rx_next;

  assign leading    = ~ecnt_q[0];
  assign sample_now = cpha ? ~leading : leading;
  assign shift_now  = cpha ? leading : (~leading && ecnt_q != LAST_EDGE);
  assign last_edge  = (ecnt_q == LAST_EDGE);
  assign step       = act_q & edge_i;
  assign rx_next    = {rx_sr[W-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      mosi_q <= 1'b0;
      ecnt_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        ecnt_q <= '0;
        lvl_q  <= 1'b0;
        if (!cpha) begin
          mosi_q <= tx[W-1];
          tx_sr  <= {tx[W-2:0], 1'b0};
        end else begin
          tx_sr  <= tx;
        end
      end else if (step) begin
        lvl_q  <= ~lvl_q;
        ecnt_q <= ecnt_q + EW'(1);
        if (sample_now) rx_sr <= rx_next;
        if (shift_now) begin
          mosi_q <= tx_sr[W-1];
          tx_sr  <= {tx_sr[W-2:0], 1'b0};
        end
        if (last_edge) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= sample_now ? rx_next : rx_sr;
        end
      end
    end
  end

  assign sck    = cpol ^ lvl_q;
  assign mosi   = mosi_q;
  assign active = act_q;
  assign done_p = done_q;
  assign rx     = rx_q;
endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
  import spi_byte_host_pkg::*;
#(
  parameter int unsigned CNT_W = HP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  input  logic              slow_tick,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  // programmable state
  logic             cpol_q, cpha_q, ien_q, rdcyc_q, block_q, fast_q;
  logic [IDX_W-1:0] div_q;
  logic [REG_W-1:0] data_q;
  logic             bd_q, te_q, held_q, ch_q, rd_lat_q;

  // named internal events
  logic             wr_data, wr_mode, wr_cycle, wr_stat, wr_bflag, wr_src;
  logic             start_req, ch_req, start_fire, end_fire;
  logic             eng_active, done_p, eng_busy, sck_edge;
  logic [REG_W-1:0] rx_byte, tx_byte;
  logic [CNT_W-1:0] half_len;

  assign wr_data  = bus_we && bus_addr == OFS_DATA;
  assign wr_mode  = bus_we && bus_addr == OFS_MODE;
  assign wr_cycle = bus_we && bus_addr == OFS_CYCLE;
  assign wr_stat  = bus_we && bus_addr == OFS_STAT;
  assign wr_bflag = bus_we && bus_addr == OFS_BFLAG;
  assign wr_src   = bus_we && bus_addr == OFS_SRC;

  assign eng_busy   = eng_active | done_p;
  assign start_req  = wr_stat && (bus_wdata[B_GO0] || bus_wdata[B_GO1]);
  assign ch_req     = ~bus_wdata[B_GO0];               // channel 0 wins a tie
  assign start_fire = start_req && !eng_busy && (!held_q || ch_req == ch_q);
  // a start in the same write takes precedence over an end command
  assign end_fire   = wr_stat && bus_wdata[B_END] && !eng_busy && !start_req;

  assign tx_byte  = rdcyc_q ? {REG_W{1'b1}} : data_q;
  assign half_len = CNT_W'(half_period(div_q, fast_q));

  spi_sck_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_active),
    .fast_src  (fast_q),
    .slow_tick (slow_tick),
    .half_len  (half_len),
    .edge_o    (sck_edge)
  );

  spi_byte_shifter #(.W(REG_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_fire),
    .tx     (tx_byte),
    .cpol   (cpol_q),
    .cpha   (cpha_q),
    .edge_i (sck_edge),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .active (eng_active),
    .done_p (done_p),
    .rx     (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      ien_q    <= 1'b0;
      div_q    <= '0;
      rdcyc_q  <= 1'b0;
      block_q  <= 1'b0;
      fast_q   <= 1'b0;
      data_q   <= '0;
      bd_q     <= 1'b0;
      te_q     <= 1'b0;
      held_q   <= 1'b0;
      ch_q     <= 1'b0;
      rd_lat_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        cpol_q <= bus_wdata[B_CPOL];
        cpha_q <= bus_wdata[B_CPHA];
        div_q  <= bus_wdata[B_DIV_LO +: IDX_W];
        ien_q  <= bus_wdata[B_IEN];
      end
      if (wr_cycle) begin
        rdcyc_q <= bus_wdata[B_RDCYC];
        block_q <= bus_wdata[B_BLOCK];
      end
      if (wr_src) fast_q <= bus_wdata[B_FAST];

      // a received byte overwrites a bus write made in the same cycle
      if (done_p && rd_lat_q) data_q <= rx_byte;
      else if (wr_data)       data_q <= bus_wdata;

      // flag updates: setting wins over write-1-clear
      bd_q <= done_p   | (bd_q & ~(wr_bflag & bus_wdata[B_BDONE]));
      te_q <= end_fire | (te_q & ~(wr_stat & bus_wdata[B_TEND]));

      if (start_fire) begin
        held_q   <= 1'b1;
        ch_q     <= ch_req;
        rd_lat_q <= rdcyc_q;
      end else if (end_fire) begin
        held_q   <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(held_q && ch_q == 1'(g));
  end

  assign irq = ien_q & (bd_q | te_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA:  bus_rdata = data_q;
      OFS_MODE: begin
        bus_rdata[B_CPOL]                = cpol_q;
        bus_rdata[B_CPHA]                = cpha_q;
        bus_rdata[B_DIV_LO +: IDX_W]     = div_q;
        bus_rdata[B_IEN]                 = ien_q;
      end
      OFS_CYCLE: begin
        bus_rdata[B_RDCYC] = rdcyc_q;
        bus_rdata[B_BLOCK] = block_q;
      end
      OFS_STAT: begin
        bus_rdata[B_DEVBSY] = held_q;
        bus_rdata[B_XIP]    = eng_active;
        bus_rdata[B_TEND]   = te_q;
        bus_rdata[B_BUSBSY] = eng_busy;
      end
      OFS_BFLAG: bus_rdata[B_BDONE] = bd_q;
      OFS_SRC:   bus_rdata[B_FAST]  = fast_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_host_chk.sv
module spi_byte_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [1:0] cs_n,
  input logic       irq,
  input logic       cpol,
  input logic       active,
  input logic       done_p,
  input logic       bd,
  input logic       te,
  input logic       start_req,
  input logic       end_fire
);
  // R4: the serial clock rests at the polarity level whenever no byte shifts
  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sck == cpol);

  // R8: never more than one chip select low
  a_r8_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8: a held select only moves on an accepted end command
  a_r8_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11 && !end_fire) |=> $stable(cs_n));

  // R12: a shifting byte always has a select asserted
  a_r12_cs_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cs_n != 2'b11);

  // R11: a start arriving mid-byte leaves the selects alone
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start_req) |=> $stable(cs_n));

  // R7: a finished byte raises the byte-done flag
  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> bd);

  // R9: an accepted end releases the selects and raises transfer end
  a_r9_end_effect: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> (te && cs_n == 2'b11));

  // R10: no pending flag, no interrupt
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bd && !te) |-> !irq);
endmodule

bind spi_byte_host spi_byte_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck       (sck),
  .cs_n      (cs_n),
  .irq       (irq),
  .cpol      (cpol_q),
  .active    (eng_active),
  .done_p    (done_p),
  .bd        (bd_q),
  .te        (te_q),
  .start_req (start_req),
  .end_fire  (end_fire)
);

// File: tb/tb_spi_byte_host.sv
`timescale 1ns/100ps
module tb_spi_byte_host;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck, mosi, miso;
  logic       slow_tick = 1'b0;
  logic [1:0] cs_n;

  always #2.5 clk = ~clk;   // 200 MHz

  spi_byte_host dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .slow_tick(slow_tick), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slow source: one pulse every third clock
  int ph = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 3;
    slow_tick <= (ph == 0);
  end

  // ---------------- slave model and scoreboard monitor ----------------
  logic [7:0] exp_q[$];
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] cap = 8'h00;
  bit         mode_cpha = 1'b0;
  int         edges = 0;
  logic       sck_prev = 1'b0;

  function automatic int bit_index(input int e, input bit ph1);
    if (!ph1) return e / 2;
    return (e == 0) ? 0 : (e - 1) / 2;
  endfunction

  assign miso = slv_byte[3'(7 - bit_index(edges, mode_cpha))];

  always @(negedge clk) begin
    if (cs_n == 2'b11) begin
      edges = 0;
    end else if (sck !== sck_prev) begin
      if (((edges % 2) == 0) != mode_cpha) cap = {cap[6:0], mosi};
      edges++;
      if (edges == 16) begin
        edges = 0;
        if (exp_q.size() == 0) chk(1'b0, "R2 byte with no expectation", cap, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(cap == e, "R2/R3 byte seen on mosi", cap, e);
        end
      end
    end
    sck_prev = sck;
  end

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_mode(input bit pol, input bit pha, input logic [2:0] idx, input bit ien);
    wr(3'h1, {1'b0, pol, pha, idx, ien, 1'b0});
    mode_cpha = pha;
  endtask

  // driver: pushes the expected wire byte, runs one byte, checks timing and result
  task automatic xfer(input bit ch, input bit rdc, input logic [7:0] tx,
                      input logic [7:0] sv, input int exp_n, input int tol,
                      input string req);
    int n;
    logic [7:0] d;
    slv_byte = sv;
    exp_q.push_back(rdc ? 8'hFF : tx);
    wr(3'h2, rdc ? 8'h04 : 8'h00);
    if (!rdc) wr(3'h0, tx);
    wr(3'h3, ch ? 8'h08 : 8'h10);
    chk(cs_n == (ch ? 2'b01 : 2'b10), "R8 only chosen select low", cs_n, ch ? 1 : 2);
    rd(3'h3, d);
    chk(d[2] == 1'b1, "R12 in-progress bit while shifting", d[2], 1);
    wait_irq(n);
    chk(n >= exp_n - tol && n <= exp_n + tol, req, n, exp_n);
    rd(3'h4, d);
    chk(d[4] == 1'b1, "R7 byte-done flag set", d, 8'h10);
    rd(3'h3, d);
    chk(d[2] == 1'b0 && d[6] == 1'b1, "R12 idle engine, select held", d, 8'h40);
    wr(3'h4, 8'h10);
    chk(irq == 1'b0, "R7 write-1 clears byte-done", irq, 0);
    if (rdc) begin
      rd(3'h0, d);
      chk(d == sv, "R3 received byte in data register", d, sv);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    int hp_fast [8] = '{2, 4, 6, 8, 10, 12, 14, 1};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R1 register reset value", d, 0);
    end
    chk(cs_n == 2'b11, "R1 selects released", cs_n, 3);
    chk(sck == 1'b0 && irq == 1'b0, "R1 sck and irq low", {sck, irq}, 0);

    // fast source, mode 0, index 0, interrupts on
    wr(3'h5, 8'h40);
    set_mode(1'b0, 1'b0, 3'd0, 1'b1);
    rd(3'h1, d);
    chk(d == 8'h02, "R5 mode register readback", d, 8'h02);

    xfer(1'b0, 1'b0, 8'hA5, 8'h00, 33, 0, "R5 index 0 byte time");
    xfer(1'b0, 1'b1, 8'h00, 8'h3C, 33, 0, "R3 read byte time");
    chk(cs_n == 2'b10, "R8 select held across bytes", cs_n, 2);

    // R11: commands during a byte (index 3, half-period 8 -> 129 clocks)
    set_mode(1'b0, 1'b0, 3'd3, 1'b1);
    exp_q.push_back(8'h96);
    wr(3'h2, 8'h00);
    wr(3'h0, 8'h96);
    wr(3'h3, 8'h10);
    repeat (10) @(negedge clk);
    wr(3'h3, 8'h08);
    wr(3'h3, 8'h10);
    wr(3'h3, 8'h20);
    chk(cs_n == 2'b10, "R11 end mid-byte ignored", cs_n, 2);
    wait_irq(n);
    chk(n == 129 - 16, "R11 byte timing unchanged by extra starts", n, 113);
    rd(3'h3, d);
    chk(d[1] == 1'b0, "R11 no transfer end from ignored end", d, 0);
    wr(3'h4, 8'h10);
    repeat (40) @(negedge clk);
    rd(3'h3, d);
    chk(d[2] == 1'b0 && exp_q.size() == 0, "R11 no extra byte started", d, 0);

    // R9 / R10: end command
    wr(3'h3, 8'h20);
    chk(cs_n == 2'b11, "R9 end releases select", cs_n, 3);
    chk(irq == 1'b1, "R10 irq from transfer end", irq, 1);
    rd(3'h3, d);
    chk(d[1] == 1'b1 && d[6] == 1'b0, "R9 transfer end set, R12 device idle", d, 2);
    wr(3'h3, 8'h22);
    rd(3'h3, d);
    chk(d[1] == 1'b1, "R9 set wins over clear in same write", d, 2);
    wr(3'h3, 8'h02);
    rd(3'h3, d);
    chk(d[1] == 1'b0 && irq == 1'b0, "R9 write-1 clears transfer end", d, 0);

    // R10: masked interrupt
    set_mode(1'b0, 1'b0, 3'd3, 1'b0);
    wr(3'h3, 8'h20);
    rd(3'h3, d);
    chk(d[1] == 1'b1 && irq == 1'b0, "R10 enable off masks irq", irq, 0);
    wr(3'h3, 8'h02);

    // R4: the other three modes on channel 1, index 1 (half-period 4 -> 65)
    for (int m = 1; m < 4; m++) begin
      set_mode(m[1], m[0], 3'd1, 1'b1);
      chk(sck == m[1], "R4 sck idles at polarity", sck, m[1]);
      xfer(1'b1, 1'b0, 8'h5A ^ 8'(m), 8'h00, 65, 0, "R4 write byte in mode");
      xfer(1'b1, 1'b1, 8'h00, 8'hC3 + 8'(m), 65, 0, "R4 read byte in mode");
      chk(sck == m[1], "R4 sck back at idle after byte", sck, m[1]);
      wr(3'h3, 8'h20);
      wr(3'h3, 8'h02);
    end

    // R5: full fast-source divider table
    for (int i = 0; i < 8; i++) begin
      set_mode(1'b0, 1'b0, 3'(i), 1'b1);
      xfer(1'b0, 1'b0, 8'(i * 37 + 1), 8'h00, 16 * hp_fast[i] + 1, 0,
           "R5 fast-source byte time");
    end
    wr(3'h3, 8'h20);
    wr(3'h3, 8'h02);

    // R6: slow source, ticks every 3 clocks
    wr(3'h5, 8'h00);
    set_mode(1'b0, 1'b0, 3'd0, 1'b1);
    xfer(1'b0, 1'b0, 8'hE1, 8'h00, 48 * 2, 1, "R6 slow index 0 byte time");
    set_mode(1'b0, 1'b0, 3'd7, 1'b1);
    xfer(1'b0, 1'b1, 8'h00, 8'h7E, 48 * 16, 1, "R6 slow index 7 byte time");
    wr(3'h3, 8'h20);
    wr(3'h3, 8'h02);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 every expected byte observed", exp_q.size(), 0);
    finish_run();
  end
endmodule